// File: doc/BRIEF.md
# Input Clock Selection Controller

This controller chooses which of three candidate input clocks (A, B, or the reference F) feeds a downstream clock-generation loop, or puts that loop into hold. In hold, the loop keeps its present state and runs with no new phase or frequency information from any input. The controller does not switch clocks itself. It produces a one-hot choice and a hold flag, and a separate glitch-free multiplexer acts on them.

There are two ways to make the choice. In manual mode, a two-bit control code picks the input. Each new code must stay unchanged for a set number of system-clock cycles before the controller accepts it, so passing values during a code change cannot cause a switch. In automatic mode, the manual code is ignored. The controller then picks the highest-priority input that has no active alarm. An input is alarmed by loss of signal, or by frequency offset while offset monitoring is enabled. If every input is alarmed, the controller enters hold.

Top module: `clk_input_select`

## Requirements
- R1: While reset is high, and after reset until the first manual code is accepted, `sel_onehot` is 3'b001 (input F) and `hold` is 0.
- R2: `sel_onehot` bit 2 means input A, bit 1 means input B and bit 0 means input F. When `hold` is 1, `sel_onehot` is all zeros. Otherwise exactly one bit is set.
- R3: In manual mode, accepted code 2'b00 selects input F.
- R4: In manual mode, accepted code 2'b01 selects input B.
- R5: In manual mode, accepted code 2'b10 selects input A.
- R6: In manual mode, accepted code 2'b11 sets `hold` and selects no input.
- R7: A code on `man_code` that differs from the current candidate must be sampled unchanged on STABLE_CYCLES consecutive rising edges to be accepted. The outputs reflect it one edge later, which is STABLE_CYCLES+1 edges after it is first sampled. A code held for fewer edges has no effect.
- R8: While `auto_en` is 1, the value of `man_code` has no effect on the outputs.
- R9: In automatic mode, the outputs follow the alarms one edge later. The fixed priority is A, then B, then F. A or B is valid when its loss-of-signal alarm is low and its offset alarm is low. F is valid when its loss-of-signal alarm is low.
- R10: In automatic mode with `fos_off` at 1, the offset alarms are ignored and only the loss-of-signal alarms decide.
- R11: In automatic mode, if no input is valid, `hold` is 1 one edge later. The controller leaves hold one edge after any input becomes valid again.
- R12: When `auto_en` falls, the outputs return one edge later to the last accepted manual code. Codes that were held stable during automatic mode count as accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| man_code | input | 2 | Manual selection code (00 F, 01 B, 10 A, 11 hold) |
| auto_en | input | 1 | 1 selects automatic alarm-driven selection |
| los_a | input | 1 | Loss-of-signal alarm, input A |
| los_b | input | 1 | Loss-of-signal alarm, input B |
| los_f | input | 1 | Loss-of-signal alarm, input F |
| fos_a | input | 1 | Frequency-offset alarm, input A |
| fos_b | input | 1 | Frequency-offset alarm, input B |
| fos_off | input | 1 | 1 disables use of the offset alarms |
| sel_onehot | output | 3 | One-hot selected input {A,B,F} |
| hold | output | 1 | Hold mode active |

## Verification
Manual mode is driven through a chain of code changes that reaches every one of the four codes from several predecessors. The output is sampled one edge before and one edge after the expected acceptance point, which separates a correct stability count from an off-by-one count. Short excursions to another code that end just before acceptance show whether the filter lets a transient through. Automatic mode is swept over all 32 alarm patterns, both with offset monitoring on and off, while the manual code keeps changing. This shows the priority order, how offset alarms are masked, the all-alarmed hold, and that manual input is ignored. A final switch back to manual mode shows that the code accepted during automatic mode is restored.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic [1:0] {
        CODE_F    = 2'b00,
        CODE_B    = 2'b01,
        CODE_A    = 2'b10,
        CODE_HOLD = 2'b11
    } mcode_e;

    localparam int NUM_SRC = 3;
    localparam int IDX_F   = 0;
    localparam int IDX_B   = 1;
    localparam int IDX_A   = 2;

    typedef struct packed {
        logic                 hold;
        logic [NUM_SRC-1:0]   sel;
    } choice_t;

    typedef struct packed {
        logic los_a;
        logic los_b;
        logic los_f;
        logic fos_a;
        logic fos_b;
    } alarm_t;

    function automatic choice_t pick_src(int idx);
        choice_t c;
        c.hold     = 1'b0;
        c.sel      = '0;
        c.sel[idx] = 1'b1;
        return c;
    endfunction

    function automatic choice_t hold_choice();
        choice_t c;
        c.hold = 1'b1;
        c.sel  = '0;
        return c;
    endfunction

    function automatic choice_t decode_code(mcode_e code);
        choice_t c;
        case (code)
            CODE_F:  c = pick_src(IDX_F);
            CODE_B:  c = pick_src(IDX_B);
            CODE_A:  c = pick_src(IDX_A);
            default: c = hold_choice();
        endcase
        return c;
    endfunction

endpackage

// File: rtl/clksel_deglitch.sv
module clksel_deglitch
    import clksel_pkg::*;
#(
    parameter int STABLE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] raw_code,
    output mcode_e     acc_code,
    output logic       acc_valid
);

    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(STABLE_CYCLES - 1);

    logic [1:0]    cand;
    logic [CW-1:0] cnt;
    logic          same;

    assign same = (raw_code == cand);

    always_ff @(posedge clk) begin
        if (rst) begin
            cand      <= 2'b00;
            cnt       <= '0;
            acc_code  <= CODE_F;
            acc_valid <= 1'b0;
        end else begin
            if (!same) begin
                cand <= raw_code;
                cnt  <= CW'(1);
            end else if (cnt != CNT_DONE) begin
                cnt <= cnt + CW'(1);
            end
            if (same && cnt == CNT_DONE) begin
                acc_code  <= mcode_e'(cand);
                acc_valid <= 1'b1;
            end
        end
    end

    // R7: a sample that disagrees with the candidate never commits a code
    assert_no_early_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (raw_code != cand) |=> ($stable(acc_code) && $stable(acc_valid)));

    // R7: once committed, the accepted code stays valid
    assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> acc_valid);

endmodule

// File: rtl/clksel_auto.sv
module clksel_auto
    import clksel_pkg::*;
(
    input  alarm_t  alarms,
    input  logic    fos_off,
    output choice_t choice
);

    logic ok_a, ok_b, ok_f;

    assign ok_a = !alarms.los_a && (fos_off || !alarms.fos_a);
    assign ok_b = !alarms.los_b && (fos_off || !alarms.fos_b);
    assign ok_f = !alarms.los_f;

    always_comb begin
        if (ok_a)      choice = pick_src(IDX_A);
        else if (ok_b) choice = pick_src(IDX_B);
        else if (ok_f) choice = pick_src(IDX_F);
        else           choice = hold_choice();
    end

endmodule

// File: rtl/clk_input_select.sv
module clk_input_select
    import clksel_pkg::*;
#(
    parameter int STABLE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] man_code,
    input  logic       auto_en,
    input  logic       los_a,
    input  logic       los_b,
    input  logic       los_f,
    input  logic       fos_a,
    input  logic       fos_b,
    input  logic       fos_off,
    output logic [2:0] sel_onehot,
    output logic       hold
);

    mcode_e  acc_code;
    logic    acc_valid;
    alarm_t  alarms;
    choice_t auto_choice;
    choice_t next_choice;
    choice_t cur_q;

    clksel_deglitch #(.STABLE_CYCLES(STABLE_CYCLES)) u_deglitch (
        .clk       (clk),
        .rst       (rst),
        .raw_code  (man_code),
        .acc_code  (acc_code),
        .acc_valid (acc_valid)
    );

    assign alarms = '{los_a: los_a, los_b: los_b, los_f: los_f,
                      fos_a: fos_a, fos_b: fos_b};

    clksel_auto u_auto (
        .alarms  (alarms),
        .fos_off (fos_off),
        .choice  (auto_choice)
    );

    always_comb begin
        if (auto_en)        next_choice = auto_choice;
        else if (acc_valid) next_choice = decode_code(acc_code);
        else                next_choice = pick_src(IDX_F);
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= pick_src(IDX_F);
        else     cur_q <= next_choice;
    end

    assign sel_onehot = cur_q.sel;
    assign hold       = cur_q.hold;

    // R1: reset lands on input F without hold
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (sel_onehot == 3'b001 && !hold));

    // R2: hold means no selection; otherwise exactly one selection
    assert_hold_empty_R2: assert property (@(posedge clk) disable iff (rst)
        hold |-> (sel_onehot == 3'b000));
    assert_single_sel_R2: assert property (@(posedge clk) disable iff (rst)
        !hold |-> $onehot(sel_onehot));

    // R9: a healthy A wins in automatic mode
    assert_auto_top_R9: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !los_a && !fos_a) |=> (sel_onehot == 3'b100 && !hold));

    // R10: offset alarms do not matter when monitoring is off
    assert_fos_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (auto_en && fos_off && !los_a) |=> (sel_onehot == 3'b100));

    // R11: all inputs alarmed in automatic mode gives hold
    assert_all_bad_R11: assert property (@(posedge clk) disable iff (rst)
        (auto_en && los_f && (los_a || (!fos_off && fos_a))
                         && (los_b || (!fos_off && fos_b))) |=> hold);

endmodule

// File: tb/tb_clk_input_select.sv
module tb_clk_input_select;

    localparam int STABLE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] man_code = 2'b00;
    logic       auto_en = 1'b0;
    logic       los_a = 0, los_b = 0, los_f = 0, fos_a = 0, fos_b = 0, fos_off = 0;
    logic [2:0] sel_onehot;
    logic       hold;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    clk_input_select #(.STABLE_CYCLES(STABLE)) dut (
        .clk(clk), .rst(rst), .man_code(man_code), .auto_en(auto_en),
        .los_a(los_a), .los_b(los_b), .los_f(los_f),
        .fos_a(fos_a), .fos_b(fos_b), .fos_off(fos_off),
        .sel_onehot(sel_onehot), .hold(hold)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        n_tests++;
        if ({hold, sel_onehot} !== exp) begin
            n_fail++;
            $display("FAIL %s: got hold=%b sel=%b, expected hold=%b sel=%b",
                     req, hold, sel_onehot, exp[3], exp[2:0]);
        end
    endtask

    function automatic logic [3:0] man_exp(input logic [1:0] c);
        case (c)
            2'b00: return 4'b0001;
            2'b01: return 4'b0010;
            2'b10: return 4'b0100;
            default: return 4'b1000;
        endcase
    endfunction

    function automatic logic [3:0] auto_exp(input logic [4:0] al, input logic off);
        logic va, vb, vf;
        va = !al[4] && (off || !al[1]);
        vb = !al[3] && (off || !al[0]);
        vf = !al[2];
        if (va) return 4'b0100;
        if (vb) return 4'b0010;
        if (vf) return 4'b0001;
        return 4'b1000;
    endfunction

    function automatic string code_req(input logic [1:0] c);
        case (c)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [1:0] seq [7];
        logic [3:0] cur;
        seq = '{2'b10, 2'b11, 2'b00, 2'b01, 2'b11, 2'b10, 2'b00};

        man_code = 2'b01;
        tick(3);
        check("R1 in reset", 4'b0001);
        rst = 1'b0;
        tick(STABLE);
        check("R1 before first accept", 4'b0001);
        tick(1);
        check("R4 first accept / R7 timing", 4'b0010);
        cur = 4'b0010;

        // R3..R6 and R7 across a chain of code changes
        for (int i = 0; i < 7; i++) begin
            man_code = seq[i];
            tick(STABLE);
            check("R7 not yet accepted", cur);
            tick(1);
            cur = man_exp(seq[i]);
            check(code_req(seq[i]), cur);
        end

        // R7: short excursions are rejected (current code 00)
        man_code = 2'b11;
        tick(STABLE - 1);
        man_code = 2'b00;
        tick(2 * STABLE);
        check("R7 glitch to hold rejected", 4'b0001);
        man_code = 2'b10;
        tick(STABLE - 1);
        man_code = 2'b01;
        tick(STABLE - 1);
        man_code = 2'b00;
        tick(2 * STABLE);
        check("R7 double glitch rejected", 4'b0001);

        // R9/R10/R11 sweep with manual code churning (R8)
        auto_en = 1'b1;
        for (int i = 0; i < 64; i++) begin
            logic [4:0] al;
            logic       off;
            al  = 5'(i);
            off = i[5];
            {los_a, los_b, los_f, fos_a, fos_b} = al;
            fos_off  = off;
            man_code = 2'(i * 3);
            tick(1);
            cur = auto_exp(al, off);
            if (cur[3])   check("R11 all alarmed", cur);
            else if (off) check("R10 offset masked", cur);
            else          check("R9 priority", cur);
        end

        // R8: stable manual codes ignored in automatic mode
        {los_a, los_b, los_f, fos_a, fos_b} = 5'b10000;
        fos_off = 1'b0;
        man_code = 2'b10;
        tick(3 * STABLE);
        check("R8 manual A ignored", 4'b0010);
        man_code = 2'b11;
        tick(3 * STABLE);
        check("R8 manual hold ignored", 4'b0010);

        // R11 enter and leave hold
        {los_a, los_b, los_f, fos_a, fos_b} = 5'b11100;
        tick(1);
        check("R11 enter hold", 4'b1000);
        los_f = 1'b0;
        tick(1);
        check("R11 leave hold to F", 4'b0001);
        los_b = 1'b0;
        tick(1);
        check("R9 B over F", 4'b0010);

        // R12: return to code accepted during automatic mode
        man_code = 2'b01;
        tick(3 * STABLE);
        check("R12 auto still rules", 4'b0010);
        {los_a, los_b, los_f, fos_a, fos_b} = 5'b00000;
        tick(1);
        check("R9 A healthy", 4'b0100);
        auto_en = 1'b0;
        tick(1);
        check("R12 back to manual B", 4'b0010);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule